// File: doc/BRIEF.md
# 64-bit Shift and Rotate Unit

This block is the shift and rotate slice of a 64-bit integer datapath. Each accepted request carries two 64-bit operands, a 5-bit immediate and a 4-bit operation code. It returns one 64-bit result. Four operations are provided: logical shift left, logical shift right, arithmetic shift right and rotate right. Each one can take its amount in three ways: from the immediate directly, from the immediate raised by half the data width (32 to 63), or from a register operand.

Requests enter on a valid/ready handshake and results leave on another. A request is taken on any clock edge where `in_valid` and `in_ready` are both high. With the output register enabled (the default), the result is presented on the next cycle. It stays there, unchanged, until the consumer raises `out_ready`. `in_ready` falls only while a result is waiting and `out_ready` is low. This lets back-pressure from the consumer stall the producer without losing or duplicating a result.

Top module: `shift_rotate_unit`

## Requirements
- R1: Operation kind is `in_op[3:2]`: 00 shift left logical, 01 shift right logical, 10 shift right arithmetic, 11 rotate right. A left shift by n gives the operand shifted up n places, with zeros filling the low bits.
- R2: A logical right shift by n fills the top n bits with zeros.
- R3: An arithmetic right shift treats the operand as signed and fills the top n bits with copies of bit 63.
- R4: Rotate right by n gives (x >> n) | (x << (64 - n)). A rotate by zero returns the operand unchanged.
- R5: Amount source is `in_op[1:0]`. With 00 the amount is `in_imm` and with 01 it is `in_imm` + 32. In both of these forms the shifted value is `in_opa`.
- R6: With `in_op[1:0]` = 10 the shifted value is `in_opb` and the amount is `in_opa[5:0]`. Bits 63:6 of `in_opa` have no effect.
- R7: With `in_op[1:0]` = 11, for every kind, the result equals `in_opa`.
- R8: A request is accepted when `in_valid` and `in_ready` are both high. Its result appears with `out_valid` high on the following cycle. `in_ready` equals `!out_valid || out_ready`.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays stable.
- R10: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_op | input | 4 | Operation kind [3:2] and amount source [1:0] |
| in_opa | input | 64 | Value for immediate forms; amount for register form |
| in_opb | input | 64 | Value for register form |
| in_imm | input | 5 | Immediate shift amount |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 64 | Result |

## Verification
The bench builds the unit at the default parameters: 64-bit data and the output register on. At this width the register form reaches all 64 amounts. The raised-immediate form reaches the upper half, 32 to 63, which a 5-bit field cannot reach on its own. Each of the four kinds is swept over every amount its forms allow, with fresh random operands per step. The sweeps are joined by sign-fill extremes, rotate-by-zero in both forms, the four pass-through codes and a stalled-consumer sequence. The stall sequence is reachable only because the output register is present.

// File: rtl/sru_pkg.sv
package sru_pkg;
  typedef enum logic [1:0] {
    K_SLL = 2'd0,
    K_SRL = 2'd1,
    K_SRA = 2'd2,
    K_ROR = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    F_IMM    = 2'd0,
    F_IMM_HI = 2'd1,
    F_VAR    = 2'd2,
    F_NONE   = 2'd3
  } form_e;
endpackage

// File: rtl/sru_operand_sel.sv
module sru_operand_sel
  import sru_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int AMT_W  = $clog2(DATA_W),
  parameter int IMM_W  = AMT_W - 1
) (
  input  form_e             form,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] value,
  output logic [AMT_W-1:0]  amt
);
  localparam logic [AMT_W-1:0] HALF = AMT_W'(DATA_W / 2);

  logic [AMT_W-1:0] imm_ext;
  assign imm_ext = AMT_W'(imm);

  always_comb begin
    unique case (form)
      F_IMM:    begin value = opa; amt = imm_ext;            end
      F_IMM_HI: begin value = opa; amt = imm_ext + HALF;     end
      F_VAR:    begin value = opb; amt = opa[AMT_W-1:0];     end
      default:  begin value = opa; amt = '0;                 end
    endcase
  end
endmodule

// File: rtl/sru_barrel.sv
module sru_barrel
  import sru_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  kind_e             kind,
  input  logic [DATA_W-1:0] value,
  input  logic [AMT_W-1:0]  amt,
  output logic [DATA_W-1:0] result
);
  logic go_left, rot, fill;
  assign go_left = (kind == K_SLL);
  assign rot     = (kind == K_ROR);
  assign fill    = (kind == K_SRA) && value[DATA_W-1];

  logic [DATA_W-1:0] value_rev, res_rev, src;
  logic [DATA_W-1:0] st [0:AMT_W];

  for (genvar b = 0; b < DATA_W; b++) begin : g_rev
    assign value_rev[b] = value[DATA_W-1-b];
    assign res_rev[b]   = st[AMT_W][DATA_W-1-b];
  end

  assign src   = go_left ? value_rev : value;
  assign st[0] = src;

  for (genvar i = 0; i < AMT_W; i++) begin : g_stage
    localparam int S = 1 << i;
    logic [S-1:0] ins;
    assign ins       = rot ? st[i][S-1:0] : {S{fill}};
    assign st[i+1]   = amt[i] ? {ins, st[i][DATA_W-1:S]} : st[i];
  end

  assign result = go_left ? res_rev : st[AMT_W];

  always_comb begin
    if (rot)
      a_r4_rot_keeps_ones: assert ($countones(result) == $countones(value));
    if (kind == K_SRA)
      a_r3_sign_kept: assert (result[DATA_W-1] == value[DATA_W-1]);
    if (go_left && amt != '0)
      a_r1_low_zero: assert (result[0] == 1'b0);
    if (kind == K_SRL && amt != '0)
      a_r2_top_zero: assert (result[DATA_W-1] == 1'b0);
  end
endmodule

// File: rtl/sru_out_stage.sv
module sru_out_stage #(
  parameter int DATA_W  = 64,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  if (REG_OUT) begin : g_reg
    logic              vld_q;
    logic [DATA_W-1:0] dat_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        dat_q <= '0;
      end else if (in_ready) begin
        vld_q <= in_valid;
        if (in_valid) dat_q <= in_data;
      end
    end

    assign in_ready  = !vld_q || out_ready;
    assign out_valid = vld_q;
    assign out_data  = dat_q;

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    a_r8_deliver: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));
    a_r8_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_data  = in_data;
  end
endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import sru_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter bit REG_OUT = 1'b1,
  parameter int AMT_W   = $clog2(DATA_W),
  parameter int IMM_W   = AMT_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_op,
  input  logic [DATA_W-1:0] in_opa,
  input  logic [DATA_W-1:0] in_opb,
  input  logic [IMM_W-1:0]  in_imm,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  kind_e             kind;
  form_e             form;
  logic [DATA_W-1:0] sel_value, shifted;
  logic [AMT_W-1:0]  sel_amt;

  assign kind = kind_e'(in_op[3:2]);
  assign form = form_e'(in_op[1:0]);

  sru_operand_sel #(.DATA_W(DATA_W), .AMT_W(AMT_W), .IMM_W(IMM_W)) u_sel (
    .form  (form),
    .opa   (in_opa),
    .opb   (in_opb),
    .imm   (in_imm),
    .value (sel_value),
    .amt   (sel_amt)
  );

  sru_barrel #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_barrel (
    .kind   (kind),
    .value  (sel_value),
    .amt    (sel_amt),
    .result (shifted)
  );

  sru_out_stage #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (shifted),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  if (REG_OUT) begin : g_chk
    a_r7_unused_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_op[1:0] == 2'b11) |=> (out_data == $past(in_opa)));
    a_r10_reset_idle: assert property (@(posedge clk)
      $past(!rst_n) |-> !out_valid);
  end
endmodule

// File: tb/shift_rotate_unit_bench.sv
module shift_rotate_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic [63:0] in_opa = '0;
  logic [63:0] in_opb = '0;
  logic [4:0]  in_imm = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  shift_rotate_unit u_shift_rotate_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_opa(in_opa), .in_opb(in_opb), .in_imm(in_imm),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [63:0] model(input logic [3:0] op, input logic [63:0] a,
                                        input logic [63:0] b, input logic [4:0] imm);
    logic [63:0] v;
    int n;
    if (op[1:0] == 2'b11) return a;
    v = (op[1:0] == 2'b10) ? b : a;
    case (op[1:0])
      2'b00:   n = imm;
      2'b01:   n = imm + 32;
      default: n = a & 64'h3F;
    endcase
    case (op[3:2])
      2'b00: return v << n;
      2'b01: return v >> n;
      2'b10: return 64'($signed(v) >>> n);
      default: return (n == 0) ? v : ((v >> n) | (v << (64 - n)));
    endcase
  endfunction

  function automatic string tag_for(input logic [3:0] op);
    if (op[1:0] == 2'b11) return "R7";
    if (op[1:0] == 2'b10) return "R6";
    if (op[1:0] == 2'b01) return "R5";
    case (op[3:2])
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b,
                      input logic [4:0] imm, input string req);
    @(negedge clk);
    in_op = op; in_opa = a; in_opb = b; in_imm = imm; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8", {63'd0, out_valid}, 64'd1);
    check(req, out_data, model(op, a, b, imm));
  endtask

  task automatic t_reset;
    check("R10", {63'd0, out_valid}, 64'd0);
    check("R10", {63'd0, in_ready}, 64'd1);
  endtask

  task automatic t_sweep;
    for (int k = 0; k < 4; k++) begin
      for (int f = 0; f < 2; f++) begin
        for (int i = 0; i < 32; i++) begin
          logic [3:0] op;
          op = {2'(k), 2'(f)};
          xfer(op, {$urandom, $urandom}, {$urandom, $urandom}, 5'(i), tag_for(op));
        end
      end
      for (int n = 0; n < 64; n++) begin
        logic [63:0] a;
        a = {$urandom, $urandom};
        a[5:0] = 6'(n);
        xfer({2'(k), 2'b10}, a, {$urandom, $urandom}, 5'($urandom), "R6");
      end
    end
  endtask

  task automatic t_sign;
    xfer(4'b1001, 64'h8000_0000_0000_0000, '0, 5'd31, "R3");
    xfer(4'b1001, 64'h7FFF_FFFF_FFFF_FFFF, '0, 5'd31, "R3");
    xfer(4'b0101, 64'h8000_0000_0000_0000, '0, 5'd31, "R2");
    xfer(4'b0001, 64'h0000_0000_0000_0001, '0, 5'd31, "R1");
  endtask

  task automatic t_rot_zero;
    xfer(4'b1100, 64'hDEAD_BEEF_0123_4567, '0, 5'd0, "R4");
    xfer(4'b1110, 64'hFFFF_FFFF_FFFF_FFC0, 64'hA5A5_0F0F_1234_8765, 5'd7, "R4");
    xfer(4'b1101, 64'h0000_0000_0000_0001, '0, 5'd0, "R5");
  endtask

  task automatic t_unused;
    for (int k = 0; k < 4; k++)
      xfer({2'(k), 2'b11}, 64'h0123_4567_89AB_CDEF, 64'hFFFF_0000_FFFF_0000, 5'd9, "R7");
  endtask

  task automatic t_backpressure;
    logic [63:0] held;
    @(negedge clk);
    out_ready = 1'b0;
    in_op = 4'b0100; in_opa = 64'hF0F0_0000_0000_0000; in_imm = 5'd4; in_valid = 1'b1;
    @(negedge clk);
    check("R8", {63'd0, out_valid}, 64'd1);
    check("R8", out_data, 64'h0F0F_0000_0000_0000);
    held = out_data;
    in_op = 4'b0000; in_opa = 64'h1; in_imm = 5'd3;
    check("R8", {63'd0, in_ready}, 64'd0);
    @(negedge clk);
    check("R9", {63'd0, out_valid}, 64'd1);
    check("R9", out_data, held);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8", out_data, 64'h8);
    @(negedge clk);
    check("R8", {63'd0, out_valid}, 64'd0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_sweep;
    t_sign;
    t_rot_zero;
    t_unused;
    t_backpressure;
    finish_run;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run;
  end
endmodule